// File: doc/BRIEF.md
# UDP Line Packet Transmitter

This block turns a stream of image bytes into Ethernet/IPv4/UDP frames that carry exactly one image line each, and presents each frame as a byte stream with valid, last and ready toward a MAC transmit port. The MAC is expected to add the preamble and the frame check sequence. Every header byte is taken from a small header RAM. A host fills this RAM once through a simple write port while the transmitter is idle. The destination and source addresses, the IP and UDP length fields and the IP header checksum are all computed off-chip and written in as plain bytes. The only exception is the UDP checksum, which always goes out as zero.

Pixel bytes enter a FIFO that holds only part of a line. A frame begins once enough bytes are waiting to cover the 42 header beats, or a whole line when the line is shorter than the header. The header is then streamed. The payload follows on the very next beat, so the block never has to store a complete line before it can send one.

Top module: `udp_line_tx`

## Requirements
- R1: Each frame is exactly 42 header beats followed by LINE_BYTES payload beats. tx_last is high on the final payload beat and on no other beat.
- R2: Header beat k (k from 0 to 39) carries header RAM byte k, where the RAM address equals the byte position in the frame.
- R3: Header beats 40 and 41, which hold the UDP checksum, carry 8'h00 whatever the RAM holds at those addresses.
- R4: Payload bytes leave in the order in which they were accepted. The first payload byte directly follows header beat 41.
- R5: tx_valid stays low while the FIFO holds fewer than min(LINE_BYTES, 42) bytes and no frame is in progress.
- R6: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value on the next cycle. No header or payload byte is skipped.
- R7: A header RAM write is ignored if it arrives while a frame is in progress, from the first header beat through the accepted last beat. A write made while idle appears in later frames.
- R8: After reset, tx_valid is low and pix_ready is high.
- R9: pix_ready is low exactly when the FIFO holds FIFO_DEPTH bytes. A byte offered while pix_ready is low is discarded.
- R10: If the FIFO runs empty during the payload, tx_valid drops. When bytes arrive again, transmission resumes with the next byte in order.
- R11: Consecutive lines produce separate frames. After an accepted last beat, tx_valid is low for at least one cycle, and each frame starts with its own full header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Header RAM write strobe, honoured only when idle |
| cfg_addr | input | $clog2(HDR_RAM_BYTES) | Header RAM byte address |
| cfg_wdata | input | 8 | Header RAM write data |
| pix_valid | input | 1 | Image byte offered |
| pix_data | input | 8 | Image byte |
| pix_ready | output | 1 | FIFO has room; a byte is taken when pix_valid and pix_ready are both high |
| tx_ready | input | 1 | MAC accepts the current byte |
| tx_valid | output | 1 | tx_data holds a frame byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The bench builds the block with LINE_BYTES = 48 and FIFO_DEPTH = 64. With a line longer than the header, the start threshold is 42. With a 64-byte FIFO, a second line can be held back while the first one stalls, which makes the full and discard behaviour reachable. The 16-byte leftover after one line lies below the threshold, so the idle hold before the next frame is exercised on real data. The settings also keep the header, stall, underrun and back-to-back cases short enough that every byte of every frame is compared.

// File: rtl/udp_line_tx.sv
module udp_line_tx #(
  parameter int LINE_BYTES    = 1024,
  parameter int FIFO_DEPTH    = 256,
  parameter int HDR_RAM_BYTES = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [$clog2(HDR_RAM_BYTES)-1:0] cfg_addr,
  input  logic [7:0]                       cfg_wdata,
  input  logic                             pix_valid,
  input  logic [7:0]                       pix_data,
  output logic                             pix_ready,
  input  logic                             tx_ready,
  output logic                             tx_valid,
  output logic [7:0]                       tx_data,
  output logic                             tx_last
);

  localparam int HDR_BYTES  = 42;
  localparam int CSUM_FIRST = 40;
  localparam int AW         = $clog2(HDR_RAM_BYTES);
  localparam int FAW        = $clog2(FIFO_DEPTH);
  localparam int LW         = $clog2(LINE_BYTES + 1);
  localparam int START_FILL = (LINE_BYTES < HDR_BYTES) ? LINE_BYTES : HDR_BYTES;

  localparam logic [AW-1:0] HDR_LAST  = AW'(HDR_BYTES - 1);
  localparam logic [AW-1:0] CSUM_ADDR = AW'(CSUM_FIRST);
  localparam logic [LW-1:0] PAY_LAST  = LW'(LINE_BYTES - 1);
  localparam logic [FAW:0]  FILL_MIN  = (FAW+1)'(START_FILL);
  localparam logic [FAW:0]  FILL_MAX  = (FAW+1)'(FIFO_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} tx_state_t;

  tx_state_t       st;
  logic [7:0]      hdr_ram  [HDR_RAM_BYTES];
  logic [7:0]      fifo_mem [FIFO_DEPTH];
  logic [FAW:0]    wp, rp, fill;
  logic [AW-1:0]   hidx;
  logic [LW-1:0]   pidx;
  logic            empty, full, push, pop;
  logic [7:0]      hdr_byte;

  assign fill      = wp - rp;
  assign empty     = (wp == rp);
  assign full      = (fill == FILL_MAX);
  assign pix_ready = !full;
  assign push      = pix_valid && !full;

  assign hdr_byte  = (hidx >= CSUM_ADDR) ? 8'h00 : hdr_ram[hidx];

  assign tx_valid  = (st == S_HDR) || ((st == S_PAY) && !empty);
  assign tx_data   = (st == S_HDR) ? hdr_byte : fifo_mem[rp[FAW-1:0]];
  assign tx_last   = (st == S_PAY) && !empty && (pidx == PAY_LAST);
  assign pop       = (st == S_PAY) && !empty && tx_ready;

  always_ff @(posedge clk) begin
    if (cfg_we && st == S_IDLE) hdr_ram[cfg_addr] <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (push) fifo_mem[wp[FAW-1:0]] <= pix_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hidx <= '0;
      pidx <= '0;
      wp   <= '0;
      rp   <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case (st)
        S_IDLE: begin
          if (fill >= FILL_MIN) begin
            st   <= S_HDR;
            hidx <= '0;
          end
        end
        S_HDR: begin
          if (tx_ready) begin
            if (hidx == HDR_LAST) begin
              st   <= S_PAY;
              pidx <= '0;
            end else begin
              hidx <= hidx + 1'b1;
            end
          end
        end
        S_PAY: begin
          if (pop) begin
            if (pidx == PAY_LAST) st <= S_IDLE;
            else                  pidx <= pidx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/udp_line_tx_chk.sv
module udp_line_tx_chk #(
  parameter int LINE_BYTES = 1024,
  parameter int FIFO_DEPTH = 256
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tx_valid,
  input logic                          tx_ready,
  input logic [7:0]                    tx_data,
  input logic                          tx_last,
  input logic                          pix_ready,
  input logic [$clog2(FIFO_DEPTH):0]   fill
);
  localparam int HDR_BYTES  = 42;
  localparam int START_FILL = (LINE_BYTES < HDR_BYTES) ? LINE_BYTES : HDR_BYTES;
  localparam int FRAME_LAST = HDR_BYTES + LINE_BYTES - 1;

  int beats;
  always_ff @(posedge clk) begin
    if (!rst_n)                                beats <= 0;
    else if (tx_valid && tx_ready && tx_last)  beats <= 0;
    else if (tx_valid && tx_ready)             beats <= beats + 1;
  end

  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |-> (beats == FRAME_LAST));

  assert_last_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_udp_csum_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && (beats == 40 || beats == 41)) |-> (tx_data == 8'h00));

  assert_start_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && beats < HDR_BYTES) |-> (int'(fill) >= START_FILL));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) <= FIFO_DEPTH) && (!pix_ready == (int'(fill) == FIFO_DEPTH)));

  assert_gap_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);
endmodule

bind udp_line_tx udp_line_tx_chk #(
  .LINE_BYTES(LINE_BYTES),
  .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_last  (tx_last),
  .pix_ready(pix_ready),
  .fill     (fill)
);

// File: tb/tb_udp_line_tx.sv
`timescale 1ns/1ps
module tb_udp_line_tx;
  localparam int LINE  = 48;
  localparam int DEPTH = 64;
  localparam int HDR   = 42;
  localparam int FLEN  = HDR + LINE;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic pix_valid = 0;
  logic [7:0] pix_data = '0;
  logic pix_ready, tx_ready = 0, tx_valid, tx_last;
  logic [7:0] tx_data;

  udp_line_tx #(.LINE_BYTES(LINE), .FIFO_DEPTH(DEPTH), .HDR_RAM_BYTES(64)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last));

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  int rdy_mode = 0, rdy_cyc = 0;
  logic [7:0] hdr_img [64];
  logic [7:0] exp_pl [LINE];
  logic [7:0] cap_d [1024];
  logic       cap_l [1024];
  int cap_n = 0, hold_err = 0, hold_pend = 0;
  logic [7:0] hold_d;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    rdy_cyc++;
    tx_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((rdy_cyc % 3) != 1) : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend != 0 && !(tx_valid && tx_data == hold_d)) hold_err++;
      hold_pend = (tx_valid && !tx_ready) ? 1 : 0;
      hold_d = tx_data;
      if (tx_valid && tx_ready && cap_n < 1024) begin
        cap_d[cap_n] = tx_data;
        cap_l[cap_n] = tx_last;
        cap_n++;
      end
    end
  end

  task automatic cfg_write(input int a, input int d, input bit idle);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = 8'(d);
    @(posedge clk); #1;
    cfg_we = 0;
    if (idle) hdr_img[a] = 8'(d);
  endtask

  task automatic push_seq(input int n, input int first, input int gap, output int acc);
    acc = 0;
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      pix_valid = 1; pix_data = 8'(first + i);
      @(negedge clk);
      if (pix_ready) acc++;
      @(posedge clk); #1;
      pix_valid = 0;
      for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
    end
  endtask

  task automatic wait_beats(input int target, input string req);
    int t = 0;
    while (cap_n < target && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(cap_n == target, req, cap_n, target);
  endtask

  task automatic check_frame(input int off, input string pl_req);
    int e_h = 0, e_c = 0, e_p = 0, e_l = 0, a = 0, x = 0;
    for (int i = 0; i < 40; i++)
      if (cap_d[off+i] != hdr_img[i] && e_h++ == 0) begin a = cap_d[off+i]; x = hdr_img[i]; end
    chk(e_h == 0, "R2 header byte", a, x);
    for (int i = 40; i < 42; i++)
      if (cap_d[off+i] != 8'h00 && e_c++ == 0) a = cap_d[off+i];
    chk(e_c == 0, "R3 udp checksum", a, 0);
    for (int i = 0; i < LINE; i++)
      if (cap_d[off+HDR+i] != exp_pl[i] && e_p++ == 0) begin a = cap_d[off+HDR+i]; x = exp_pl[i]; end
    chk(e_p == 0, pl_req, a, x);
    for (int i = 0; i < FLEN; i++)
      if (cap_l[off+i] != (i == FLEN-1)) e_l++;
    chk(e_l == 0, "R1 last flag placement", e_l, 0);
  endtask

  task automatic t_reset;
    chk(tx_valid == 1'b0, "R8 tx_valid after reset", tx_valid, 0);
    chk(pix_ready == 1'b1, "R8 pix_ready after reset", pix_ready, 1);
  endtask

  task automatic t_basic;
    int acc, b = cap_n;
    rdy_mode = 0;
    push_seq(41, 0, 0, acc);
    repeat (6) @(negedge clk);
    chk(!tx_valid && cap_n == b, "R5 no start below threshold", tx_valid, 0);
    push_seq(7, 41, 0, acc);
    for (int i = 0; i < LINE; i++) exp_pl[i] = 8'(i);
    wait_beats(b + FLEN, "R1 frame beat count");
    check_frame(b, "R4 payload order");
  endtask

  task automatic t_stall_cfg;
    int acc, b = cap_n;
    rdy_mode = 2;
    push_seq(48, 50, 0, acc);
    repeat (2) @(negedge clk);
    chk(tx_valid == 1'b1, "R6 frame waiting on ready", tx_valid, 1);
    cfg_write(5, 8'h55, 0);
    rdy_mode = 1;
    for (int i = 0; i < LINE; i++) exp_pl[i] = 8'(50 + i);
    wait_beats(b + FLEN, "R6 stalled frame beat count");
    check_frame(b, "R6 payload under stalls");
    chk(cap_d[b+5] == hdr_img[5], "R7 busy write ignored", cap_d[b+5], hdr_img[5]);
    chk(hold_err == 0, "R6 byte held while not ready", hold_err, 0);
    rdy_mode = 0;
    cfg_write(5, 8'h5A, 1);
    b = cap_n;
    push_seq(48, 120, 0, acc);
    for (int i = 0; i < LINE; i++) exp_pl[i] = 8'(120 + i);
    wait_beats(b + FLEN, "R7 frame after idle write");
    chk(cap_d[b+5] == 8'h5A, "R7 idle write applied", cap_d[b+5], 8'h5A);
    check_frame(b, "R4 payload after idle write");
  endtask

  task automatic t_underrun;
    int acc, b = cap_n;
    rdy_mode = 0;
    push_seq(42, 10, 0, acc);
    push_seq(6, 52, 30, acc);
    for (int i = 0; i < LINE; i++) exp_pl[i] = 8'(10 + i);
    wait_beats(b + FLEN, "R10 frame beat count");
    check_frame(b, "R10 payload resumes in order");
  endtask

  task automatic t_full_b2b;
    int acc, b = cap_n;
    rdy_mode = 2;
    push_seq(70, 100, 0, acc);
    chk(acc == DEPTH, "R9 bytes accepted until full", acc, DEPTH);
    @(negedge clk);
    chk(pix_ready == 1'b0, "R9 pix_ready low when full", pix_ready, 0);
    rdy_mode = 0;
    for (int i = 0; i < LINE; i++) exp_pl[i] = 8'(100 + i);
    wait_beats(b + FLEN, "R9 first frame beat count");
    check_frame(b, "R9 first frame payload");
    b = cap_n;
    push_seq(32, 200, 0, acc);
    for (int i = 0; i < 16; i++) exp_pl[i] = 8'(148 + i);
    for (int i = 16; i < LINE; i++) exp_pl[i] = 8'(200 + i - 16);
    wait_beats(b + FLEN, "R11 second frame beat count");
    check_frame(b, "R9 discarded bytes absent");
  endtask

  initial begin
    #800000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 64; i++) cfg_write(i, 8'hA0 + i, 1);
    t_basic();
    t_stall_cfg();
    t_underrun();
    t_full_b2b();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule